// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one 32-bit integer by another over several clock cycles and returns both the quotient and the remainder. A caller puts the two operands and a mode bit on the inputs and raises `start` for one cycle while the unit is idle. The unit then holds `busy` high until the result is ready and marks that moment with a one-cycle `done` pulse. The results stay on the outputs until the next operation completes.

The arithmetic runs on a single unsigned restoring engine that produces one quotient bit per clock. For signed operands the magnitudes go into the engine and the signs are put back in a final cycle. None of the inputs causes a fault, because every combination of operands has a defined answer. A zero divisor gives a quotient with every bit set and a remainder equal to the dividend, in both modes. The one signed case that overflows, the most negative value divided by minus one, gives the most negative value as the quotient and zero as the remainder.

Top module: `int_divider`

## Requirements
- R1: With `is_signed` low, the operands are unsigned. For a non-zero divisor, `quotient` is the floor of dividend/divisor, and `remainder` = dividend − quotient·divisor, which is below the divisor.
- R2: With `is_signed` high, the operands are two's complement. For a non-zero divisor that is not the overflow case, the quotient is truncated toward zero, so it is negative exactly when the operand signs differ and it is non-zero.
- R3: In signed mode with a non-zero divisor, the remainder has the sign of the dividend (or is zero), its magnitude is below that of the divisor, and quotient·divisor + remainder equals the dividend.
- R4: A zero divisor produces a quotient with all bits set (0xFFFFFFFF) in both modes, with no other signalling.
- R5: A zero divisor produces a remainder equal to the dividend bit for bit, in both modes.
- R6: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: `start` is accepted at a rising edge where `busy` is low. `busy` is then high for exactly WIDTH+2 cycles, and it falls at the same edge that raises `done`.
- R8: `done` is high for exactly one cycle per accepted operation.
- R9: `start` has no effect while `busy` is high. The running operation finishes with the operands it captured.
- R10: `quotient` and `remainder` change only at the edge that raises `done`, and they hold their values in between.
- R11: While `rst_n` is low, `busy` and `done` are low and `quotient` and `remainder` are zero.
- R12: A `start` presented in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new division (taken only when idle) |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled when start is accepted |
| divisor | input | 32 | Divisor, sampled when start is accepted |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results valid from this cycle |
| quotient | output | 32 | Quotient of the last completed operation |
| remainder | output | 32 | Remainder of the last completed operation |

## Verification
The bench covers zero divisors in both modes and with negative dividends. A design that applied the sign-difference rule blindly would return 1 instead of all ones for −7/0, and a design that dropped the dividend sign would return a positive remainder. It also covers the most negative value over −1 in both modes, where a wrong sign fixup gives a positive or saturated quotient, and all four sign combinations with small operands, where the remainder's sign is easy to get wrong. On the control side, the bench raises `start` in the middle of a running operation and again in the cycle where `done` is high. A handshake fault shows up either as corrupted results or as a lost back-to-back request.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIX   = 2'd3
  } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic             is_signed,
  input  logic [WIDTH-1:0] num,
  input  logic [WIDTH-1:0] den,
  output logic [WIDTH-1:0] num_mag,
  output logic [WIDTH-1:0] den_mag,
  output logic             num_neg,
  output logic             den_neg
);

  always_comb begin
    num_neg = is_signed & num[WIDTH-1];
    den_neg = is_signed & den[WIDTH-1];
    num_mag = num_neg ? (~num + {{(WIDTH-1){1'b0}}, 1'b1}) : num;
    den_mag = den_neg ? (~den + {{(WIDTH-1){1'b0}}, 1'b1}) : den;
  end

endmodule

// File: rtl/div_restore_core.sv
module div_restore_core #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] num_mag,
  input  logic [WIDTH-1:0] den_mag,
  output logic [WIDTH-1:0] quo,
  output logic [WIDTH-1:0] rem
);

  localparam int TW = WIDTH + 2;

  logic [WIDTH-1:0] rem_q, rem_d;
  logic [WIDTH-1:0] quo_q, quo_d;
  logic [WIDTH-1:0] den_q, den_d;
  logic [TW-1:0]    trial;
  logic             fits;
  logic             en;

  // One restoring step: shift the next dividend bit into the partial
  // remainder, try the subtraction, keep it when it does not borrow.
  always_comb begin
    trial = {1'b0, rem_q, quo_q[WIDTH-1]} - {2'b00, den_q};
    fits  = ~trial[TW-1];
    en    = load | step;
    rem_d = rem_q;
    quo_d = quo_q;
    den_d = den_q;
    if (load) begin
      rem_d = '0;
      quo_d = num_mag;
      den_d = den_mag;
    end else if (step) begin
      rem_d = fits ? trial[WIDTH-1:0] : {rem_q[WIDTH-2:0], quo_q[WIDTH-1]};
      quo_d = {quo_q[WIDTH-2:0], fits};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

endmodule

// File: rtl/div_sign_fix.sv
module div_sign_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  input  logic             neg_quo,
  input  logic             neg_rem,
  output logic [WIDTH-1:0] quo_out,
  output logic [WIDTH-1:0] rem_out
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    quo_out = neg_quo ? (~quo_mag + ONE) : quo_mag;
    rem_out = neg_rem ? (~rem_mag + ONE) : rem_mag;
  end

endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int               CNT_W    = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  div_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [WIDTH-1:0] a_q, b_q;
  logic             sgn_q;
  logic             cap_en;
  logic             res_en;
  logic             done_q, done_d;
  logic [WIDTH-1:0] quo_q, rem_q;

  logic [WIDTH-1:0] a_mag, b_mag;
  logic             a_neg, b_neg;
  logic             b_zero;
  logic [WIDTH-1:0] core_quo, core_rem;
  logic [WIDTH-1:0] fix_quo, fix_rem;
  logic             neg_quo, neg_rem;

  // ---------------- next-state logic ----------------
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    cap_en  = 1'b0;
    res_en  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        cnt_d   = '0;
        cnt_en  = 1'b1;
        state_d = ST_ITER;
      end
      ST_ITER: begin
        cnt_d  = cnt_q + CNT_ONE;
        cnt_en = 1'b1;
        if (cnt_q == LAST_BIT) state_d = ST_FIX;
      end
      ST_FIX: begin
        res_en  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // ---------------- datapath ----------------
  div_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .is_signed (sgn_q),
    .num       (a_q),
    .den       (b_q),
    .num_mag   (a_mag),
    .den_mag   (b_mag),
    .num_neg   (a_neg),
    .den_neg   (b_neg)
  );

  div_restore_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (state_q == ST_SETUP),
    .step    (state_q == ST_ITER),
    .num_mag (a_mag),
    .den_mag (b_mag),
    .quo     (core_quo),
    .rem     (core_rem)
  );

  // A zero divisor keeps the core's all-ones quotient in both modes, and
  // the remainder sign follows the dividend, so it returns the dividend.
  always_comb begin
    b_zero  = (b_q == '0);
    neg_quo = (a_neg ^ b_neg) & ~b_zero;
    neg_rem = a_neg;
  end

  div_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .quo_mag (core_quo),
    .rem_mag (core_rem),
    .neg_quo (neg_quo),
    .neg_rem (neg_rem),
    .quo_out (fix_quo),
    .rem_out (fix_rem)
  );

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      sgn_q <= 1'b0;
    end else if (cap_en) begin
      a_q   <= dividend;
      b_q   <= divisor;
      sgn_q <= is_signed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
    end else if (res_en) begin
      quo_q <= fix_quo;
      rem_q <= fix_rem;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             is_signed,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);

  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0]   cap_a, cap_b;
  logic               cap_s;
  logic [15:0]        busy_len;
  logic [2*WIDTH-1:0] recon;

  // Operands as seen at the port when the request was taken (R9: only idle starts)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      cap_s <= 1'b0;
    end else if (start && !busy) begin
      cap_a <= dividend;
      cap_b <= divisor;
      cap_s <= is_signed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 16'd1;
    else           busy_len <= '0;
  end

  assign recon = {{WIDTH{1'b0}}, quotient} * {{WIDTH{1'b0}}, cap_b}
               + {{WIDTH{1'b0}}, remainder};

  p_reset_state_r11: assert property (@(posedge clk)
    !rst_n |-> (!busy && !done && quotient == '0 && remainder == '0));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_len == 16'(WIDTH + 2) && !busy));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));

  p_unsigned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_s && cap_b != '0) |->
      (recon == {{WIDTH{1'b0}}, cap_a} && remainder < cap_b));

  p_divzero_quo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_b == '0) |-> (quotient == '1));

  p_divzero_rem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_b == '0) |-> (remainder == cap_a));

  p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_s && cap_a == MOST_NEG && cap_b == '1) |->
      (quotient == MOST_NEG && remainder == '0));

  p_rem_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_s && cap_b != '0 && remainder != '0) |->
      (remainder[WIDTH-1] == cap_a[WIDTH-1]));

endmodule

bind int_divider div_checker #(.WIDTH(WIDTH)) u_div_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .is_signed (is_signed),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/int_divider_test.sv
module int_divider_test;

  localparam int W      = 32;
  localparam int LAT    = W + 2;
  localparam int WD_MAX = 150000;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         is_signed;
  logic [W-1:0] dividend;
  logic [W-1:0] divisor;
  logic         busy;
  logic         done;
  logic [W-1:0] quotient;
  logic [W-1:0] remainder;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  int_divider #(.WIDTH(W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_signed (is_signed),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  // ---------------- behavioural reference ----------------
  bit           m_busy, m_done;
  int           m_left;
  logic [W-1:0] m_q, m_r, m_pend_q, m_pend_r;
  string        m_qtag, m_rtag, m_ptq, m_ptr;
  bit           any_done;

  task automatic ref_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                         output logic [W-1:0] q, output logic [W-1:0] r,
                         output string tq, output string tr);
    longint sa, sb;
    if (b == '0) begin
      q = '1; r = a; tq = "R4"; tr = "R5";
    end else if (!s) begin
      q = a / b; r = a % b; tq = "R1"; tr = "R1";
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      q = 32'h8000_0000; r = '0; tq = "R6"; tr = "R6";
    end else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = W'(sa / sb); r = W'(sa % sb); tq = "R2"; tr = "R3";
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_q = '0; m_r = '0; any_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; any_done = 1;
          m_q = m_pend_q; m_r = m_pend_r; m_qtag = m_ptq; m_rtag = m_ptr;
        end
      end else if (start) begin  // R9: only an idle unit takes start
        m_busy = 1; m_left = LAT;
        ref_div(dividend, divisor, is_signed, m_pend_q, m_pend_r, m_ptq, m_ptr);
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      string tq, tr;
      if (!rst_n || !any_done) begin tq = "R11"; tr = "R11"; end
      else if (!m_done)         begin tq = "R10"; tr = "R10"; end
      else                      begin tq = m_qtag; tr = m_rtag; end
      chk("R7", "busy", W'(busy), W'(m_busy));
      chk("R8", "done", W'(done), W'(m_done));
      chk(tq, "quotient", quotient, m_q);
      chk(tr, "remainder", remainder, m_r);
    end
  end

  task automatic summary;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_MAX) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
    dividend = a; divisor = b; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    while (!done) @(negedge clk);
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
    @(negedge clk);
    while (busy) @(negedge clk);
    issue(a, b, s);
    wait_done();
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0;
    dividend = '0; divisor = '0;
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);        // R11 checked each cycle in reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(32'd100, 32'd7, 1'b0);                 // R1
    run_op(32'hFFFF_FFFF, 32'd1, 1'b0);           // R1
    run_op(32'd3, 32'd9, 1'b0);                   // R1
    run_op(32'd0, 32'd5, 1'b1);                   // R2
    run_op(32'd5, 32'd0, 1'b0);                   // R4 R5 unsigned
    run_op(32'd5, 32'd0, 1'b1);                   // R4 R5 signed
    run_op(-32'sd7, 32'd0, 1'b1);                 // R4 R5 negative dividend
    run_op(-32'sd7, 32'd2, 1'b1);                 // R2 R3: -3, -1
    run_op(32'd7, -32'sd2, 1'b1);                 // R2 R3: -3, 1
    run_op(-32'sd7, -32'sd2, 1'b1);               // R2 R3: 3, -1
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);   // R6
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0);   // R1: 0 rem 0x80000000

    // R9: a second start mid-operation must not disturb the first
    run_op(32'd1000, 32'd3, 1'b0);
    @(negedge clk);
    issue(32'd1000, 32'd3, 1'b0);
    @(negedge clk);
    issue(32'd9, 32'd9, 1'b1);
    wait_done();
    chk("R9", "quotient", quotient, 32'd333);
    chk("R9", "remainder", remainder, 32'd1);

    // R12: start in the done cycle is taken
    issue(32'd50, 32'd6, 1'b0);
    chk("R12", "busy", W'(busy), W'(1));
    wait_done();
    chk("R12", "quotient", quotient, 32'd8);

    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      a = $urandom();
      b = $urandom();
      case (i % 5)
        1: b = b & 32'h0000_00FF;
        2: b = '0;
        3: begin a = 32'h8000_0000; b = (i % 2) ? 32'hFFFF_FFFF : 32'd1; end
        4: b = -(b & 32'hF);
        default: ;
      endcase
      run_op(a, b, 1'((i / 5) % 2));
    end

    repeat (3) @(negedge clk);   // R10: outputs hold while idle
    summary();
  end

endmodule